// File: doc/BRIEF.md
# Boot-Block Flash Write-Protection Controller

This block is the command and protection front end of a byte-wide flash device holding 2^17 bytes. It sits between an SRAM-like bus (active-low chip select, output enable and write enable, a 17-bit address, 8-bit data in and out) and a small behavioural storage array. Bus writes are captured inside the block. A command state machine accepts read-array, read-status, clear-status, byte-program and block-erase sequences. Program and erase requests are granted or refused according to the target block, a boot-unlock input, an active-low powerdown input and a programming-supply-valid flag.

The address space is split into four erase blocks of unequal size: an 8 KB boot block, two 4 KB parameter blocks and a 112 KB main block. The `TOP_BOOT` parameter places the boot block at the top of the space, or mirrors the map so that it sits at the bottom. The behavioural array keeps 2^`LOC_W` bytes per block, addressed by the low address bits. Every accepted operation holds the device busy for `BUSY_CYC` cycles.

States: `ST_ARRAY` (reads return array data), `ST_STATUS` (reads return the status byte), `ST_PGM_ARM` (program command seen, waiting for the address/data write), `ST_ERS_ARM` (erase command seen, waiting for the confirm write), `ST_BUSY` (operation in progress). Transitions: a command write in `ST_ARRAY`/`ST_STATUS` goes to the state the command names. An accepted program or erase goes to `ST_BUSY`. A refused one goes to `ST_STATUS` with an error bit set. A bad erase confirm goes to `ST_ARRAY`. `ST_BUSY` goes to `ST_STATUS` when its counter runs out. Powerdown forces `ST_ARRAY` from any state.

Top module: `bootflash_guard`

## Requirements
- R1: With TOP_BOOT=1 the map is: main 0x00000–0x1BFFF, parameter-0 0x1C000–0x1CFFF, parameter-1 0x1D000–0x1DFFF, boot 0x1E000–0x1FFFF. Within a block, a cell is selected by address bits [LOC_W-1:0].
- R2: With TOP_BOOT=0 the map is mirrored: boot 0x00000–0x01FFF, parameter-0 0x02000–0x02FFF, parameter-1 0x03000–0x03FFF, main 0x04000–0x1FFFF.
- R3: Command bytes: 0xFF selects read-array mode, 0x70 selects status mode, 0x50 clears the error bits and selects read-array mode, 0x40 arms a program, 0x20 arms an erase. Any other byte selects read-array mode.
- R4: A write is taken on the cycle in which we_n rises while ce_n is low. It uses the address and data held during the last cycle that we_n was low. After 0x40, the next write stores its data byte at its address.
- R5: After 0x20, a write of 0xD0 sets every byte of the block addressed by that write to 0xFF. Any other confirm byte leaves the array unchanged and selects read-array mode.
- R6: A program or erase aimed at the boot block while boot_unlock is low is refused: the array is unchanged and status bit 4 (program) or bit 5 (erase) is set. With boot_unlock high it is carried out.
- R7: While vpp_ok is low, every program or erase is refused in the same way and the array is unchanged.
- R8: Programming or erasing one block leaves the data of every other block unchanged.
- R9: The status byte is {ready, 0, erase_error, program_error, 4'b0}. ready is 0 for BUSY_CYC cycles after an accepted operation, and writes are ignored during that time. The block then enters status mode. Error bits stay set until 0x50.
- R10: While pwd_n is low, writes are ignored, dq_oe is low and the error bits are cleared. After pwd_n rises, the block is in read-array mode.
- R11: dq_oe is high only when ce_n, oe_n are low and pwd_n is high. Otherwise the data bus is released.
- R12: After reset the array holds 0xFF everywhere, the block is in read-array mode, and the status byte reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe |
| addr | input | AW | Byte address |
| din | input | 8 | Write data / command byte |
| dq_out | output | 8 | Read data (array byte or status byte) |
| dq_oe | output | 1 | Data bus drive enable |
| pwd_n | input | 1 | Active-low powerdown |
| boot_unlock | input | 1 | Boot-block write unlock |
| vpp_ok | input | 1 | Programming supply valid |

## Verification
The assertions assume that pwd_n is held high throughout reset, so that the first post-reset sample of the powerdown-exit check is defined. They also assume that boot_unlock and vpp_ok change only between write strobes, so the grant decision made on a we_n rise sees stable gate inputs. The bench drives every input on the falling clock edge. It changes the gate inputs only while the bus is idle, and it scrambles din right as we_n rises, which shows that the data from the low phase is the data used. A second instance built for the bottom-boot map shares the stimulus, so one address sequence exercises both maps.

// File: rtl/bfg_pkg.sv
package bfg_pkg;
    typedef enum logic [1:0] {
        BLK_MAIN = 2'd0,
        BLK_PAR0 = 2'd1,
        BLK_PAR1 = 2'd2,
        BLK_BOOT = 2'd3
    } blk_e;

    typedef enum logic [2:0] {
        ST_ARRAY   = 3'd0,
        ST_STATUS  = 3'd1,
        ST_PGM_ARM = 3'd2,
        ST_ERS_ARM = 3'd3,
        ST_BUSY    = 3'd4
    } st_e;

    localparam logic [7:0] OP_READ   = 8'hFF;
    localparam logic [7:0] OP_STAT   = 8'h70;
    localparam logic [7:0] OP_CLR    = 8'h50;
    localparam logic [7:0] OP_PGM    = 8'h40;
    localparam logic [7:0] OP_ERS    = 8'h20;
    localparam logic [7:0] OP_CONF   = 8'hD0;
endpackage

// File: rtl/bfg_decode.sv
module bfg_decode
    import bfg_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic [4:0] hi,
    output blk_e       blk
);
    // hi holds the five most significant address bits
    generate
        if (TOP_BOOT) begin : g_top
            always_comb begin
                if (hi[4:1] == 4'hF)        blk = BLK_BOOT;
                else if (hi == 5'b11101)    blk = BLK_PAR1;
                else if (hi == 5'b11100)    blk = BLK_PAR0;
                else                        blk = BLK_MAIN;
            end
        end else begin : g_bottom
            always_comb begin
                if (hi[4:1] == 4'h0)        blk = BLK_BOOT;
                else if (hi == 5'b00010)    blk = BLK_PAR0;
                else if (hi == 5'b00011)    blk = BLK_PAR1;
                else                        blk = BLK_MAIN;
            end
        end
    endgenerate
endmodule

// File: rtl/bfg_array.sv
module bfg_array
    import bfg_pkg::*;
#(
    parameter int LOC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_en,
    input  logic             erase_en,
    input  blk_e             wblk,
    input  logic [LOC_W-1:0] woff,
    input  logic [7:0]       wdata,
    input  blk_e             rblk,
    input  logic [LOC_W-1:0] roff,
    output logic [7:0]       rdata
);
    localparam int DEPTH = 4 << LOC_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (erase_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (2'(i >> LOC_W) == wblk) mem[i] <= 8'hFF;
            end
        end else if (prog_en) begin
            mem[{wblk, woff}] <= wdata;
        end
    end

    assign rdata = mem[{rblk, roff}];
endmodule

// File: rtl/bfg_ctrl.sv
module bfg_ctrl
    import bfg_pkg::*;
#(
    parameter int AW       = 17,
    parameter int BUSY_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwd_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    input  logic          boot_unlock,
    input  logic          vpp_ok,
    input  blk_e          wblk,
    output logic [AW-1:0] lat_addr,
    output logic [7:0]    lat_data,
    output logic          prog_en,
    output logic          erase_en,
    output logic          show_status,
    output logic [7:0]    status,
    output st_e           state
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    st_e           nxt;
    logic [CW-1:0] cnt, nxt_cnt;
    logic          we_q, p_err, e_err;
    logic          set_p, set_e, clr_err;
    logic          wr_rise, allowed;

    // bus capture: hold address/data of the low phase of we_n
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q     <= 1'b1;
            lat_addr <= '0;
            lat_data <= '0;
        end else begin
            we_q <= we_n;
            if (!we_n && !ce_n) begin
                lat_addr <= addr;
                lat_data <= din;
            end
        end
    end

    assign wr_rise = pwd_n && !ce_n && !we_q && we_n;
    assign allowed = vpp_ok && ((wblk != BLK_BOOT) || boot_unlock);

    // next-state logic
    always_comb begin
        nxt     = state;
        nxt_cnt = cnt;
        set_p   = 1'b0;
        set_e   = 1'b0;
        clr_err = 1'b0;
        unique case (state)
            ST_ARRAY, ST_STATUS: begin
                if (wr_rise) begin
                    case (lat_data)
                        OP_READ: nxt = ST_ARRAY;
                        OP_STAT: nxt = ST_STATUS;
                        OP_CLR:  begin nxt = ST_ARRAY; clr_err = 1'b1; end
                        OP_PGM:  nxt = ST_PGM_ARM;
                        OP_ERS:  nxt = ST_ERS_ARM;
                        default: nxt = ST_ARRAY;
                    endcase
                end
            end
            ST_PGM_ARM: begin
                if (wr_rise) begin
                    if (allowed) begin
                        nxt     = ST_BUSY;
                        nxt_cnt = CW'(BUSY_CYC - 1);
                    end else begin
                        nxt   = ST_STATUS;
                        set_p = 1'b1;
                    end
                end
            end
            ST_ERS_ARM: begin
                if (wr_rise) begin
                    if (lat_data != OP_CONF) begin
                        nxt = ST_ARRAY;
                    end else if (allowed) begin
                        nxt     = ST_BUSY;
                        nxt_cnt = CW'(BUSY_CYC - 1);
                    end else begin
                        nxt   = ST_STATUS;
                        set_e = 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (cnt == '0) nxt = ST_STATUS;
                else           nxt_cnt = cnt - 1'b1;
            end
            default: nxt = ST_ARRAY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || !pwd_n) begin
            state <= ST_ARRAY;
            cnt   <= '0;
            p_err <= 1'b0;
            e_err <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= nxt_cnt;
            p_err <= (p_err && !clr_err) || set_p;
            e_err <= (e_err && !clr_err) || set_e;
        end
    end

    // outputs
    always_comb begin
        prog_en     = (state == ST_PGM_ARM) && wr_rise && allowed;
        erase_en    = (state == ST_ERS_ARM) && wr_rise && allowed && (lat_data == OP_CONF);
        show_status = (state != ST_ARRAY);
        status      = {state != ST_BUSY, 1'b0, e_err, p_err, 4'b0000};
    end
endmodule

// File: rtl/bootflash_guard.sv
module bootflash_guard
    import bfg_pkg::*;
#(
    parameter int AW       = 17,
    parameter bit TOP_BOOT = 1'b1,
    parameter int LOC_W    = 4,
    parameter int BUSY_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic [7:0]    dq_out,
    output logic          dq_oe,
    input  logic          pwd_n,
    input  logic          boot_unlock,
    input  logic          vpp_ok
);
    logic [AW-1:0] lat_addr;
    logic [7:0]    lat_data, status, rdata;
    logic          prog_en, erase_en, show_status;
    blk_e          wblk, rblk;
    st_e           state;

    bfg_decode #(.TOP_BOOT(TOP_BOOT)) u_dec_w (
        .hi (lat_addr[AW-1:AW-5]),
        .blk(wblk)
    );

    bfg_decode #(.TOP_BOOT(TOP_BOOT)) u_dec_r (
        .hi (addr[AW-1:AW-5]),
        .blk(rblk)
    );

    bfg_ctrl #(.AW(AW), .BUSY_CYC(BUSY_CYC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwd_n      (pwd_n),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .addr       (addr),
        .din        (din),
        .boot_unlock(boot_unlock),
        .vpp_ok     (vpp_ok),
        .wblk       (wblk),
        .lat_addr   (lat_addr),
        .lat_data   (lat_data),
        .prog_en    (prog_en),
        .erase_en   (erase_en),
        .show_status(show_status),
        .status     (status),
        .state      (state)
    );

    bfg_array #(.LOC_W(LOC_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .prog_en (prog_en),
        .erase_en(erase_en),
        .wblk    (wblk),
        .woff    (lat_addr[LOC_W-1:0]),
        .wdata   (lat_data),
        .rblk    (rblk),
        .roff    (addr[LOC_W-1:0]),
        .rdata   (rdata)
    );

    assign dq_out = show_status ? status : rdata;
    assign dq_oe  = pwd_n && !ce_n && !oe_n;
endmodule

// File: rtl/bfg_chk.sv
module bfg_chk
    import bfg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       pwd_n,
    input logic       vpp_ok,
    input logic       boot_unlock,
    input logic       dq_oe,
    input logic       prog_en,
    input logic       erase_en,
    input logic [1:0] wblk,
    input logic [2:0] st
);
    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n || !pwd_n) |-> !dq_oe); // R11

    AST_PWD_LOCKS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        !pwd_n |-> !(prog_en || erase_en)); // R10

    AST_PWD_EXIT_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwd_n) |-> (st == 3'(ST_ARRAY))); // R10

    AST_VPP_LOCKS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_ok |-> !(prog_en || erase_en)); // R7

    AST_BOOT_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ((prog_en || erase_en) && (wblk == 2'(BLK_BOOT))) |-> boot_unlock); // R6

    AST_ONE_OPERATION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_en, erase_en})); // R4

    AST_OP_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwd_n && (prog_en || erase_en)) |=> (!pwd_n || (st == 3'(ST_BUSY)))); // R9
endmodule

bind bootflash_guard bfg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .pwd_n      (pwd_n),
    .vpp_ok     (vpp_ok),
    .boot_unlock(boot_unlock),
    .dq_oe      (dq_oe),
    .prog_en    (prog_en),
    .erase_en   (erase_en),
    .wblk       (wblk),
    .st         (state)
);

// File: tb/sim_bootflash_guard.sv
`timescale 1ns/1ps
module sim_bootflash_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic        pwd_n = 1'b1, boot_unlock = 1'b0, vpp_ok = 1'b1;
    logic [7:0]  dq0, dq1;
    logic        oe0, oe1;
    int          n_cmp = 0, n_bad = 0;
    logic [7:0]  r0, r1;
    logic        e0, e1;

    always #2 clk = ~clk;

    bootflash_guard #(.TOP_BOOT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dq_out(dq0), .dq_oe(oe0),
        .pwd_n(pwd_n), .boot_unlock(boot_unlock), .vpp_ok(vpp_ok)
    );

    bootflash_guard #(.TOP_BOOT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dq_out(dq1), .dq_oe(oe1),
        .pwd_n(pwd_n), .boot_unlock(boot_unlock), .vpp_ok(vpp_ok)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic bus_wr(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        @(negedge clk); we_n = 1'b1; din = ~d; addr = ~a;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [16:0] a);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
        #1; r0 = dq0; r1 = dq1; e0 = oe0; e1 = oe1;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #1;
        check("R11 oe_n high releases bus", {7'd0, oe0}, 8'd0);
        ce_n = 1'b1;
        bus_rd(17'h00013);
        check("R12 erased after reset", r0, 8'hFF);
        check("R12 drives in read", {7'd0, e0}, 8'd1);
        bus_wr(17'h0, 8'h70);
        bus_rd(17'h0);
        check("R12 R3 status idle", r0, 8'h80);
    endtask

    task automatic t_program();
        bus_wr(17'h0, 8'hFF);
        bus_wr(17'h00013, 8'h40);
        bus_wr(17'h00013, 8'hA5);
        bus_rd(17'h00013);
        check("R9 busy ready low", r0, 8'h00);
        settle();
        bus_rd(17'h00013);
        check("R9 status after op", r0, 8'h80);
        bus_wr(17'h0, 8'hFF);
        bus_rd(17'h00013);
        check("R4 programmed byte", r0, 8'hA5);
    endtask

    task automatic t_isolation();
        bus_wr(17'h1D003, 8'h40);
        bus_wr(17'h1D003, 8'h3C);
        settle();
        bus_wr(17'h0, 8'hFF);
        bus_rd(17'h1D003);
        check("R1 param1 byte", r0, 8'h3C);
        bus_rd(17'h1C003);
        check("R8 R1 param0 untouched", r0, 8'hFF);
        bus_rd(17'h00013);
        check("R8 main untouched", r0, 8'hA5);
    endtask

    task automatic t_bootlock();
        bus_wr(17'h1E005, 8'h40);
        bus_wr(17'h1E005, 8'h00);
        bus_rd(17'h0);
        check("R6 boot program refused", r0, 8'h90);
        bus_wr(17'h0, 8'hFF);
        bus_rd(17'h1E005);
        check("R6 boot unchanged", r0, 8'hFF);
        bus_wr(17'h0, 8'h70);
        bus_rd(17'h0);
        check("R9 error sticky", r0, 8'h90);
        bus_wr(17'h0, 8'h50);
        bus_wr(17'h0, 8'h70);
        bus_rd(17'h0);
        check("R9 R3 clear status", r0, 8'h80);
    endtask

    task automatic t_unlock();
        boot_unlock = 1'b1;
        bus_wr(17'h1E005, 8'h40);
        bus_wr(17'h1E005, 8'h5A);
        settle();
        boot_unlock = 1'b0;
        bus_wr(17'h0, 8'hFF);
        bus_rd(17'h1E005);
        check("R6 boot programmed when unlocked", r0, 8'h5A);
    endtask

    task automatic t_vpp();
        vpp_ok = 1'b0;
        bus_wr(17'h00014, 8'h40);
        bus_wr(17'h00014, 8'h77);
        bus_rd(17'h0);
        check("R7 program refused", r0, 8'h90);
        bus_wr(17'h0, 8'h50);
        bus_wr(17'h00000, 8'h20);
        bus_wr(17'h00000, 8'hD0);
        bus_rd(17'h0);
        check("R7 erase refused", r0, 8'hA0);
        vpp_ok = 1'b1;
        bus_wr(17'h0, 8'h50);
        bus_rd(17'h00014);
        check("R7 program had no effect", r0, 8'hFF);
        bus_rd(17'h00013);
        check("R7 erase had no effect", r0, 8'hA5);
    endtask

    task automatic t_erase();
        bus_wr(17'h1D000, 8'h20);
        bus_wr(17'h1D000, 8'hD0);
        settle();
        bus_wr(17'h0, 8'hFF);
        bus_rd(17'h1D003);
        check("R5 param1 erased", r0, 8'hFF);
        bus_rd(17'h00013);
        check("R8 main kept", r0, 8'hA5);
        bus_rd(17'h1E005);
        check("R8 boot kept", r0, 8'h5A);
        bus_wr(17'h1E000, 8'h20);
        bus_wr(17'h1E000, 8'hD0);
        bus_rd(17'h0);
        check("R6 boot erase refused", r0, 8'hA0);
        bus_wr(17'h0, 8'h50);
        bus_rd(17'h1E005);
        check("R6 boot survives", r0, 8'h5A);
        bus_wr(17'h00000, 8'h20);
        bus_wr(17'h00000, 8'h33);
        bus_rd(17'h00013);
        check("R5 bad confirm to array", r0, 8'hA5);
        bus_wr(17'h0, 8'h70);
        bus_wr(17'h0, 8'h99);
        bus_rd(17'h00013);
        check("R3 unknown byte to array", r0, 8'hA5);
    endtask

    task automatic t_tristate();
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; #1;
        check("R11 ce_n high releases bus", {7'd0, oe0}, 8'd0);
        oe_n = 1'b1;
    endtask

    task automatic t_powerdown();
        bus_wr(17'h1E005, 8'h40);
        bus_wr(17'h1E005, 8'h00);
        bus_rd(17'h0);
        check("R6 refused before powerdown", r0, 8'h90);
        @(negedge clk); pwd_n = 1'b0;
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; #1;
        check("R10 bus released in powerdown", {7'd0, oe0}, 8'd0);
        ce_n = 1'b1; oe_n = 1'b1;
        bus_wr(17'h00016, 8'h40);
        bus_wr(17'h00016, 8'h22);
        @(negedge clk); pwd_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_rd(17'h00016);
        check("R10 array mode, write ignored", r0, 8'hFF);
        bus_wr(17'h0, 8'h70);
        bus_rd(17'h0);
        check("R10 errors cleared", r0, 8'h80);
    endtask

    task automatic t_bottom();
        settle(); bus_wr(17'h0, 8'hFF);
        settle(); bus_wr(17'h0, 8'hFF);
        bus_wr(17'h0, 8'h50);
        bus_wr(17'h04005, 8'h40);
        bus_wr(17'h04005, 8'h5A);
        settle();
        bus_wr(17'h00005, 8'h40);
        bus_wr(17'h00005, 8'h11);
        bus_rd(17'h0);
        check("R2 bottom boot refused", r1, 8'h90);
        settle();
        bus_wr(17'h0, 8'hFF);
        bus_rd(17'h04005);
        check("R2 bottom main programmed", r1, 8'h5A);
        bus_rd(17'h02005);
        check("R2 bottom param0 untouched", r1, 8'hFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_program();
        t_isolation();
        t_bootlock();
        t_unlock();
        t_vpp();
        t_erase();
        t_tristate();
        t_powerdown();
        t_bottom();
        summary();
    end
endmodule